// File: doc/BRIEF.md
# Ethernet Egress Frame Length and FCS Binning

This block watches a byte-wide egress Ethernet frame stream. Each byte comes with a valid strobe, and start-of-frame and end-of-frame markers. The block sorts every completed frame into a set of overlapping statistics bins. It counts the bytes of the frame, including the trailing four-byte FCS. It runs a CRC-32 over the whole frame and decides whether the FCS is correct, wrong, or stomped. A stomped FCS is the bitwise complement of the correct value.

One cycle after the byte that carries the end marker, the block raises single-cycle strobes for the bins that apply. Statistics counters elsewhere in the chip accumulate these strobes. A maximum length, a minimum length and an ignore-FCS control program the binning. All three are captured when a frame starts.

Top module: `eth_frame_binner`

## Requirements
- R1: While reset is asserted and directly after it is released, all seven strobes are low.
- R2: Strobes are registered. They appear exactly one clock after the accepted byte that carries the end marker, last one cycle, and appear at no other time.
- R3: A frame longer than the maximum length raises `toolong_o`. It also raises `oversize_o` when its FCS counts as good, or `jabber_o` when it counts as bad.
- R4: A frame shorter than the minimum length raises `undersize_o` when its FCS counts as good, or `fragment_o` when it counts as bad. The two are never raised together.
- R5: `bad_fcs_o` is raised for a frame with a wrong FCS (stomped included) only when its length L satisfies 64 <= L <= maximum.
- R6: The FCS is the CRC-32 (reflected polynomial 0xEDB88320, all-ones preset, final complement) over all bytes except the last four, sent least significant byte first. A received FCS equal to the complement of that value raises `stomped_o`, and it is also a wrong FCS.
- R7: With `ignore_fcs_i` high, a wrong-FCS frame is sorted into the length bins as if its FCS were good. `bad_fcs_o` and `stomped_o` are still raised.
- R8: `max_len_i`, `min_len_i` and `ignore_fcs_i` are captured on the start byte. Changing them later in the frame has no effect on that frame.
- R9: The length counts every accepted byte of the frame, FCS included. It saturates at 32767, so a frame of any greater length is still oversized.
- R10: Cycles with `valid_i` low add nothing to the frame. Bytes that arrive outside a frame (no start marker seen) are ignored, and so is an end marker outside a frame.
- R11: A frame may start on the cycle right after the previous frame's end byte. Each frame is then binned on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte on `data_i` is valid |
| sof_i | input | 1 | Valid byte is the first of a frame |
| eof_i | input | 1 | Valid byte is the last of a frame |
| data_i | input | 8 | Frame byte |
| max_len_i | input | 15 | Maximum length; legal 64..16383, bit 14 reserved 0 |
| min_len_i | input | 8 | Minimum length |
| ignore_fcs_i | input | 1 | Sort wrong-FCS frames as good |
| jabber_o | output | 1 | Oversized with bad FCS |
| oversize_o | output | 1 | Oversized with good FCS |
| toolong_o | output | 1 | Oversized, either FCS status |
| undersize_o | output | 1 | Undersized with good FCS |
| fragment_o | output | 1 | Undersized with bad FCS |
| bad_fcs_o | output | 1 | Wrong FCS, length 64..maximum |
| stomped_o | output | 1 | FCS is the complement of the correct value |

## Verification
Some rules are checked by assertions on every cycle:
- strobes only follow an accepted end byte;
- `oversize_o` and `jabber_o` exclude each other, and either one goes with `toolong_o`;
- `undersize_o` and `fragment_o` exclude each other;
- the captured thresholds stay frozen inside a frame;
- the length counter holds during idle cycles, steps by one per byte and saturates.

Other behaviour only the directed scenarios can show:
- that the bins are correct at the exact 63/64 and maximum/maximum+1 boundaries;
- that stomped and single-bit-corrupted FCS values are told apart;
- that ignore-FCS moves frames between bins;
- that stray bytes and mid-frame threshold changes have no effect;
- that a frame longer than the counter range still reads as oversized.

// File: rtl/eth_bin_pkg.sv
package eth_bin_pkg;
  localparam logic [31:0] CRC_POLY_R    = 32'hEDB88320;
  // register content after a whole frame with correct / complemented FCS
  localparam logic [31:0] CRC_RES_GOOD  = 32'hDEBB20E3;
  localparam logic [31:0] CRC_RES_STOMP = 32'h0000_0000;
  localparam int unsigned BAD_FCS_MIN_LEN = 64;

  typedef struct packed {
    logic jabber;
    logic oversize;
    logic toolong;
    logic undersize;
    logic fragment;
    logic bad_fcs;
    logic stomped;
  } bin_flags_t;
endpackage

// File: rtl/ebin_frame_tracker.sv
module ebin_frame_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic take_o,
  output logic start_o,
  output logic end_o
);
  logic in_frame_q;

  assign start_o = valid_i & sof_i;
  assign take_o  = valid_i & (sof_i | in_frame_q);
  assign end_o   = take_o & eof_i;

  // a start marker inside a frame abandons the old frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_frame_q <= 1'b0;
    else if (end_o)   in_frame_q <= 1'b0;
    else if (start_o) in_frame_q <= 1'b1;
  end

  assert_stray_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_q && !start_o) |-> !take_o);
endmodule

// File: rtl/ebin_len_counter.sv
module ebin_len_counter #(
  parameter int unsigned LEN_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             start_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] cnt_q, base;

  assign base  = start_i ? '0 : cnt_q;
  assign len_o = (base == LEN_MAX) ? LEN_MAX : base + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_i) cnt_q <= len_o;
  end

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(cnt_q));
  assert_len_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i && cnt_q == LEN_MAX) |=> cnt_q == LEN_MAX);
  assert_len_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i && cnt_q != LEN_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ebin_crc_engine.sv
module ebin_crc_engine
  import eth_bin_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [31:0]       crc_next_o
);
  logic [31:0] crc_q, base;
  logic [DATA_W:0][31:0] stage;

  assign base     = start_i ? '1 : crc_q;
  assign stage[0] = base ^ {{(32-DATA_W){1'b0}}, data_i};

  // one reflected shift per data bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ CRC_POLY_R) : (stage[g] >> 1);
  end

  assign crc_next_o = stage[DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (take_i) crc_q <= crc_next_o;
  end

  assert_crc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(crc_q));
endmodule

// File: rtl/ebin_classifier.sv
module ebin_classifier
  import eth_bin_pkg::*;
#(
  parameter int unsigned LEN_W = 15,
  parameter int unsigned MIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      residue_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic [MIN_W-1:0] min_len_i,
  input  logic             ignore_fcs_i,
  output bin_flags_t       flags_o
);
  localparam logic [LEN_W-1:0] BAD_LO = LEN_W'(BAD_FCS_MIN_LEN);

  logic fcs_bad, fcs_stomp, bin_bad, over, under;
  bin_flags_t flags_d, flags_q;

  assign fcs_stomp = (residue_i == CRC_RES_STOMP);
  assign fcs_bad   = (residue_i != CRC_RES_GOOD);
  assign bin_bad   = fcs_bad & ~ignore_fcs_i;
  assign over      = len_i > max_len_i;
  assign under     = len_i < {{(LEN_W-MIN_W){1'b0}}, min_len_i};

  always_comb begin
    flags_d = '0;
    if (eval_i) begin
      flags_d.toolong   = over;
      flags_d.jabber    = over & bin_bad;
      flags_d.oversize  = over & ~bin_bad;
      flags_d.fragment  = under & bin_bad;
      flags_d.undersize = under & ~bin_bad;
      flags_d.bad_fcs   = fcs_bad & (len_i >= BAD_LO) & ~over;
      flags_d.stomped   = fcs_stomp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  assert_over_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_q.oversize && flags_q.jabber));
  assert_toolong_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q.oversize || flags_q.jabber) == flags_q.toolong);
  assert_under_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_q.undersize && flags_q.fragment));
  assert_bad_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.bad_fcs |-> !flags_q.toolong);
endmodule

// File: rtl/eth_frame_binner.sv
module eth_frame_binner
  import eth_bin_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MAX_W  = 15,
  parameter int unsigned MIN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [MAX_W-1:0]  max_len_i,
  input  logic [MIN_W-1:0]  min_len_i,
  input  logic              ignore_fcs_i,
  output logic              jabber_o,
  output logic              oversize_o,
  output logic              toolong_o,
  output logic              undersize_o,
  output logic              fragment_o,
  output logic              bad_fcs_o,
  output logic              stomped_o
);
  localparam int unsigned LEN_W = MAX_W;

  logic take, start, fend;
  logic [LEN_W-1:0] len_fin;
  logic [31:0] crc_next;
  logic [MAX_W-1:0] max_q, max_eff;
  logic [MIN_W-1:0] min_q, min_eff;
  logic ign_q, ign_eff;
  bin_flags_t flags;

  ebin_frame_tracker u_track (
    .clk_i, .rst_ni, .valid_i, .sof_i, .eof_i,
    .take_o(take), .start_o(start), .end_o(fend)
  );

  ebin_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni, .take_i(take), .start_i(start), .len_o(len_fin)
  );

  ebin_crc_engine #(.DATA_W(DATA_W)) u_crc (
    .clk_i, .rst_ni, .take_i(take), .start_i(start), .data_i,
    .crc_next_o(crc_next)
  );

  // thresholds frozen at frame start; a one-byte frame uses the live values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '0;
      min_q <= '0;
      ign_q <= 1'b0;
    end else if (start) begin
      max_q <= max_len_i;
      min_q <= min_len_i;
      ign_q <= ignore_fcs_i;
    end
  end

  assign max_eff = start ? max_len_i    : max_q;
  assign min_eff = start ? min_len_i    : min_q;
  assign ign_eff = start ? ignore_fcs_i : ign_q;

  ebin_classifier #(.LEN_W(LEN_W), .MIN_W(MIN_W)) u_cls (
    .clk_i, .rst_ni, .eval_i(fend), .len_i(len_fin), .residue_i(crc_next),
    .max_len_i(max_eff), .min_len_i(min_eff), .ignore_fcs_i(ign_eff),
    .flags_o(flags)
  );

  assign jabber_o    = flags.jabber;
  assign oversize_o  = flags.oversize;
  assign toolong_o   = flags.toolong;
  assign undersize_o = flags.undersize;
  assign fragment_o  = flags.fragment;
  assign bad_fcs_o   = flags.bad_fcs;
  assign stomped_o   = flags.stomped;

  assert_pulse_after_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags) |-> $past(fend));
  assert_thr_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> ($stable(max_q) && $stable(min_q) && $stable(ign_q)));
endmodule

// File: tb/eth_frame_binner_bench.sv
module eth_frame_binner_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0, ignore_fcs_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [14:0] max_len_i = 15'd1518;
  logic [7:0] min_len_i = 8'd64;
  logic jabber_o, oversize_o, toolong_o, undersize_o, fragment_o, bad_fcs_o, stomped_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] fa [0:39999];
  logic [7:0] fb [0:39999];

  always #2 clk_i = ~clk_i;

  eth_frame_binner u_eth_frame_binner (.*);

  wire [6:0] obs = {jabber_o, oversize_o, toolong_o, undersize_o, fragment_o, bad_fcs_o, stomped_o};

  task automatic chk(input logic [6:0] act, input logic [6:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // kind: 0 good, 1 one bit flipped, 2 complemented
  task automatic build(input int len, input int kind, input bit to_b);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] f;
    logic [7:0] b;
    for (int i = 0; i < len - 4; i++) begin
      b = 8'((i * 7 + len) & 255);
      if (to_b) fb[i] = b; else fa[i] = b;
      c = c ^ {24'b0, b};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    f = ~c;
    if (kind == 1) f = f ^ 32'h0000_0100;
    if (kind == 2) f = ~f;
    for (int j = 0; j < 4; j++) begin
      if (to_b) fb[len-4+j] = f[8*j +: 8]; else fa[len-4+j] = f[8*j +: 8];
    end
  endtask

  function automatic logic [6:0] expect_bins(input int len, input int kind, input int mx,
                                             input int mn, input bit ign);
    bit bad = (kind != 0);
    bit eb = bad && !ign;
    bit over = len > mx;
    bit under = len < mn;
    return {over && eb, over && !eb, over, under && !eb, under && eb,
            bad && len >= 64 && len <= mx, kind == 2};
  endfunction

  task automatic put(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk_i);
    valid_i = 1'b1; sof_i = s; eof_i = e; data_i = b;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
  endtask

  // sends fa[0:len-1]; optional idle gaps and a mid-frame max change
  task automatic send(input int len, input logic [6:0] exp, input string tag,
                      input bit gaps = 0, input int chg_at = -1, input int chg_val = 0);
    for (int i = 0; i < len; i++) begin
      if (i == chg_at) max_len_i = 15'(chg_val);
      if (gaps && (i % 3 == 1)) idle();
      put(fa[i], i == 0, i == len - 1);
    end
    idle();
    chk(obs, exp, tag);
    idle();
    chk(obs, 7'b0, {tag, " R2 single cycle"});
  endtask

  task automatic run(input int len, input int kind, input string tag);
    build(len, kind, 0);
    send(len, expect_bins(len, kind, int'(max_len_i), int'(min_len_i), ignore_fcs_i), tag);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(obs, 7'b0, "R1 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(obs, 7'b0, "R1 after reset");
  endtask

  task automatic t_basic();
    max_len_i = 15'd1518; min_len_i = 8'd64; ignore_fcs_i = 1'b0;
    run(100, 0, "R6 good 100");
    run(64, 0, "R4 good 64");
    run(63, 0, "R4 good 63 undersize");
    run(30, 1, "R4 bad 30 fragment");
    run(64, 1, "R5 bad 64");
    run(63, 1, "R5 bad 63 no bad_fcs");
  endtask

  task automatic t_max_edge();
    max_len_i = 15'd200;
    run(200, 0, "R3 good at max");
    run(201, 0, "R3 good over max");
    run(201, 1, "R3 bad over max jabber");
    run(200, 1, "R5 bad at max");
  endtask

  task automatic t_stomp();
    max_len_i = 15'd200;
    run(100, 2, "R6 stomped 100");
    run(30, 2, "R6 stomped 30");
    run(220, 2, "R6 stomped 220");
  endtask

  task automatic t_ignore();
    max_len_i = 15'd200; ignore_fcs_i = 1'b1;
    run(30, 1, "R7 ignore bad 30");
    run(100, 1, "R7 ignore bad 100");
    run(201, 2, "R7 ignore stomped 201");
    run(201, 0, "R7 ignore good 201");
    ignore_fcs_i = 1'b0;
  endtask

  task automatic t_stray_gaps();
    max_len_i = 15'd1518;
    put(8'hAA, 0, 0); put(8'h55, 0, 0); put(8'h12, 0, 1);
    idle();
    chk(obs, 7'b0, "R10 stray end ignored");
    build(70, 0, 0);
    send(70, 7'b0, "R10 idle gaps good 70", 1'b1);
    build(63, 0, 0);
    send(63, 7'b0001000, "R10 idle gaps good 63", 1'b1);
  endtask

  task automatic t_mid_change();
    max_len_i = 15'd200;
    build(150, 0, 0);
    send(150, 7'b0, "R8 max lowered mid-frame", 1'b0, 20, 100);
    max_len_i = 15'd200;
    build(150, 1, 0);
    ignore_fcs_i = 1'b0;
    for (int i = 0; i < 150; i++) begin
      if (i == 10) begin ignore_fcs_i = 1'b1; min_len_i = 8'd255; end
      put(fa[i], i == 0, i == 149);
    end
    idle();
    chk(obs, 7'b0000010, "R8 ignore/min changed mid-frame");
    ignore_fcs_i = 1'b0; min_len_i = 8'd64;
  endtask

  task automatic t_b2b();
    max_len_i = 15'd200;
    build(201, 0, 0);
    build(40, 1, 1);
    for (int i = 0; i < 201; i++) put(fa[i], i == 0, i == 200);
    for (int i = 0; i < 40; i++) begin
      put(fb[i], i == 0, i == 39);
      if (i == 0) chk(obs, 7'b0110000, "R11 first frame");
      if (i == 1) chk(obs, 7'b0, "R11 R2 gap between");
    end
    idle();
    chk(obs, 7'b0000100, "R11 second frame");
    idle();
  endtask

  task automatic t_saturate();
    max_len_i = 15'd16383;
    run(33000, 0, "R9 saturated length oversized");
    run(16384, 0, "R9 16384 oversized");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_max_edge();
    t_stomp();
    t_ignore();
    t_stray_gaps();
    t_mid_change();
    t_b2b();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule